// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block recovers an I2C bus that a target left stuck after a transfer was cut short. Such a target holds SDA low while it waits for clock edges that never arrive. A single-cycle start request can be raised at initialization or after an error. If the bus then reports busy, or the synchronized SDA reads low, the sequencer takes the pins away from the main I2C controller and drives SCL itself. It holds SCL low for one dwell interval. It then clocks the line with up to a bounded number of pulses. Before each pulse it checks SDA and stops as soon as the target lets go.

After the pulses it releases SCL for one more dwell interval. It then hands the pins back to the controller and raises a one-cycle done flag. A stuck status travels with the done flag. It reports whether SDA was still low after the last allowed pulse. A request made while the bus is already free skips the takeover and completes at once. All pins are plain control and status signals. The block carries no data stream, so it has no valid/ready handshake.

Top module: `bus_clear_seq`

## Requirements
- R1: While reset is asserted, and after it, before any start request, pin_owner_o, scl_pull_low_o, done_o and stuck_o are all 0.
- R2: In idle, a start_i request is accepted only if bus_busy_i is 1 or the synchronized SDA is 0. Otherwise the pins are never taken, and done_o is 1 in the cycle after the request with stuck_o 0.
- R3: After an accepted request, pin_owner_o and scl_pull_low_o are both 1 from the next cycle on, for exactly DWELL_CYCLES cycles. scl_pull_low_o is never 1 unless pin_owner_o is 1.
- R4: Each pulse releases SCL (scl_pull_low_o 0) for DWELL_CYCLES cycles and then pulls it low for DWELL_CYCLES cycles.
- R5: The synchronized SDA is sampled in the last cycle of every low phase. If it is 1, no further pulse is issued.
- R6: At most MAX_PULSES pulses are issued per run. If SDA is still 0 at the sample after the last pulse, the run ends with stuck_o 1.
- R7: After the low phase where pulsing ends, SCL is released with pin_owner_o still 1 for DWELL_CYCLES cycles. In the following cycle pin_owner_o is 0 and done_o is 1, for that one cycle only.
- R8: stuck_o changes only in the cycle where done_o is 1, and it holds its value until the next completion.
- R9: start_i is ignored while a run is in progress. Each run produces exactly one done_o cycle.
- R10: sda_i passes through SYNC_STAGES flops (default 2) before it is used. A new level on sda_i does not affect a decision at the first rising edge after it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to clear the bus |
| bus_busy_i | input | 1 | Bus-busy indication from the I2C controller |
| sda_i | input | 1 | Asynchronous SDA pin level |
| scl_pull_low_o | output | 1 | 1 pulls SCL low (open drain); 0 releases it |
| pin_owner_o | output | 1 | 1 gives the pins to the sequencer; 0 gives them to the controller |
| done_o | output | 1 | One-cycle completion flag |
| stuck_o | output | 1 | SDA still low after the last allowed pulse; valid from done_o |

## Verification
The hardest case to reach from the ports is a target that lets go after a chosen number of pulses. The release has to land inside a high phase and cross the synchronizer before the next sample. To produce it, the bench acts as a target that counts the SCL rising edges it sees and releases SDA after N of them. Runs cover N = 0, a few mid values, exactly the pulse limit, one more than the limit, and a target that never lets go. A second hard case is a start request issued one cycle after SDA falls. The synchronizer must still show the old level there, so the request has to complete without a takeover.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PRE_LOW = 3'd1,
    ST_HIGH    = 3'd2,
    ST_LOW     = 3'd3,
    ST_RELEASE = 3'd4,
    ST_DONE    = 3'd5
  } bcs_state_e;
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RESET_VAL;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RESET_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bcs_dwell_timer.sv
module bcs_dwell_timer #(
  parameter int DWELL_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expired_o
);
  localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LAST);
endmodule

// File: rtl/bcs_pulse_count.sv
module bcs_pulse_count #(
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic inc_i,
  output logic limit_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PULSES);

  logic [PW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count_q <= '0;
    else if (clear_i)                  count_q <= '0;
    else if (inc_i && count_q != LIMIT) count_q <= count_q + 1'b1;
  end

  assign limit_o = (count_q == LIMIT);
endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq
  import bcs_pkg::*;
#(
  parameter int DWELL_CYCLES = 100000,
  parameter int MAX_PULSES   = 10,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bus_busy_i,
  input  logic sda_i,
  output logic scl_pull_low_o,
  output logic pin_owner_o,
  output logic done_o,
  output logic stuck_o
);
  bcs_state_e state_q, state_d;
  logic sda_s;
  logic expired;
  logic at_limit;
  logic accept;
  logic in_low;
  logic stuck_pend_q;
  logic stuck_q;
  logic owner_q, scl_low_q, done_q;

  // SDA crosses into the clock domain before any decision uses it.
  bcs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sda_i),
    .q_o   (sda_s)
  );

  // Phase timer restarts on every state change.
  bcs_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (state_q != state_d),
    .expired_o (expired)
  );

  assign in_low = (state_q == ST_PRE_LOW) || (state_q == ST_LOW);

  bcs_pulse_count #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .inc_i   (in_low && (state_d == ST_HIGH)),
    .limit_o (at_limit)
  );

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (bus_busy_i || !sda_s) begin
            state_d = ST_PRE_LOW;
            accept  = 1'b1;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_PRE_LOW, ST_LOW: begin
        if (expired) begin
          if (sda_s || at_limit) state_d = ST_RELEASE;
          else                   state_d = ST_HIGH;
        end
      end
      ST_HIGH:    if (expired) state_d = ST_LOW;
      ST_RELEASE: if (expired) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Level seen at each low-phase sample; the last one decides the status.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stuck_pend_q <= 1'b0;
    else if (in_low && expired) stuck_pend_q <= !sda_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stuck_q <= 1'b0;
    else if (state_d == ST_DONE)
      stuck_q <= (state_q == ST_RELEASE) && stuck_pend_q;
  end

  // Registered outputs decoded from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q   <= 1'b0;
      scl_low_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      owner_q   <= (state_d == ST_PRE_LOW) || (state_d == ST_HIGH) ||
                   (state_d == ST_LOW)     || (state_d == ST_RELEASE);
      scl_low_q <= (state_d == ST_PRE_LOW) || (state_d == ST_LOW);
      done_q    <= (state_d == ST_DONE);
    end
  end

  assign pin_owner_o    = owner_q;
  assign scl_pull_low_o = scl_low_q;
  assign done_o         = done_q;
  assign stuck_o        = stuck_q;
endmodule

// File: rtl/bus_clear_seq_chk.sv
module bus_clear_seq_chk #(
  parameter int MAX_PULSES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic scl_pull_low_o,
  input logic pin_owner_o,
  input logic done_o,
  input logic stuck_o
);
  logic prev_low_q;
  int   rel_cnt_q;

  // Counts SCL releases while the sequencer owns the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low_q <= 1'b0;
      rel_cnt_q  <= 0;
    end else begin
      prev_low_q <= scl_pull_low_o;
      if (done_o)
        rel_cnt_q <= 0;
      else if (pin_owner_o && prev_low_q && !scl_pull_low_o)
        rel_cnt_q <= rel_cnt_q + 1;
    end
  end

  p_scl_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low_o |-> pin_owner_o);

  p_first_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_owner_o) |-> scl_pull_low_o);

  p_take_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_owner_o) |-> $past(start_i));

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt_q <= MAX_PULSES + 1);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pin_owner_o && !scl_pull_low_o));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_owner_o |=> (pin_owner_o || done_o));

  p_stuck_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(stuck_o));
endmodule

bind bus_clear_seq bus_clear_seq_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .scl_pull_low_o (scl_pull_low_o),
  .pin_owner_o    (pin_owner_o),
  .done_o         (done_o),
  .stuck_o        (stuck_o)
);

// File: tb/tb_bus_clear_seq.sv
module tb_bus_clear_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 5;
  localparam int MAXP       = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy = 1'b0;
  logic sda = 1'b1;
  logic scl_low, owner, done, stuck;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_clear_seq #(.DWELL_CYCLES(DWELL), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .bus_busy_i     (busy),
    .sda_i          (sda),
    .scl_pull_low_o (scl_low),
    .pin_owner_o    (owner),
    .done_o         (done),
    .stuck_o        (stuck)
  );

  // Reference model: 0 idle, 1 SCL low, 2 SCL high, 3 final release, 4 done.
  int m_phase = 0, m_left = 0, m_pulses = 0;
  bit m_s1 = 1, m_s2 = 1, m_pend = 0, m_stuck = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_pulses = 0;
      m_s1 = 1; m_s2 = 1; m_pend = 0; m_stuck = 0;
    end else begin
      bit seen;
      seen = m_s2;
      case (m_phase)
        0: if (start) begin
             if (busy || !seen) begin m_phase = 1; m_left = DWELL; m_pulses = 0; end
             else begin m_phase = 4; m_stuck = 0; end
           end
        1: begin
             m_left--;
             if (m_left == 0) begin
               m_pend = !seen;
               m_left = DWELL;
               if (seen || m_pulses == MAXP) m_phase = 3;
               else begin m_phase = 2; m_pulses++; end
             end
           end
        2: begin
             m_left--;
             if (m_left == 0) begin m_phase = 1; m_left = DWELL; end
           end
        3: begin
             m_left--;
             if (m_left == 0) begin m_phase = 4; m_stuck = m_pend; end
           end
        default: m_phase = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = sda;
    end
  end

  // Emulated target: holds SDA low until it has seen hold_left SCL rises.
  int hold_left = 0;
  bit hold_forever = 0;
  bit prev_low = 0;
  int rises = 0;
  int dones = 0;

  always @(negedge clk) begin
    bit e_owner, e_low, e_done;
    e_owner = (m_phase >= 1 && m_phase <= 3);
    e_low   = (m_phase == 1);
    e_done  = (m_phase == 4);
    vectors++;
    if (owner !== e_owner || scl_low !== e_low || done !== e_done || stuck !== m_stuck) begin
      miscompares++;
      $display("FAIL R3/R4/R7/R8 cycle compare: act owner=%0b scl_low=%0b done=%0b stuck=%0b exp owner=%0b scl_low=%0b done=%0b stuck=%0b",
               owner, scl_low, done, stuck, e_owner, e_low, e_done, m_stuck);
    end
    if (owner && prev_low && !scl_low) begin
      rises++;
      if (hold_left > 0) hold_left--;
    end
    if (done) dones++;
    prev_low = scl_low;
    sda = !(hold_forever || hold_left > 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  // One bus-clear attempt; lead = cycles between target setup and start.
  task automatic run(input bit busy_v, input int hold_n, input bit forever_v,
                     input int lead, input bit extra_start,
                     input int exp_rises, input bit exp_stuck, input string tag);
    int waited;
    @(negedge clk); #1;
    hold_left = hold_n; hold_forever = forever_v; busy = busy_v;
    repeat (lead) @(negedge clk);
    #1;
    rises = 0; dones = 0;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    waited = 0;
    while (dones == 0 && waited < 400) begin
      if (extra_start && waited == 7) start = 1'b1;
      if (extra_start && waited == 8) start = 1'b0;
      @(negedge clk); #1;
      waited++;
    end
    chk(rises == exp_rises, {tag, " SCL releases"}, rises, exp_rises);
    chk(stuck == exp_stuck, {tag, " stuck_o"}, stuck, exp_stuck);
    chk(owner == 1'b0, {tag, " pins returned"}, owner, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(dones == 1, {tag, " single done"}, dones, 1);
    hold_left = 0; hold_forever = 0; busy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(owner == 0 && scl_low == 0 && done == 0 && stuck == 0, "R1 reset outputs", {owner, scl_low, done, stuck}, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(owner == 0 && scl_low == 0 && done == 0 && stuck == 0, "R1 after reset", {owner, scl_low, done, stuck}, 0);

    // R2: free bus, SDA high -> no takeover.
    run(1'b0, 0, 1'b0, 4, 1'b0, 0, 1'b0, "R2 free bus");
    // R5: busy bus with SDA high -> only the initial low, then release.
    run(1'b1, 0, 1'b0, 4, 1'b0, 1, 1'b0, "R5 busy SDA high");
    // R4 / R5: target lets go after a few pulses.
    run(1'b0, 1, 1'b0, 4, 1'b0, 2, 1'b0, "R5 release after 1");
    run(1'b0, 3, 1'b0, 4, 1'b0, 4, 1'b0, "R4 release after 3");
    // R6: release exactly at the limit, one past it, and never.
    run(1'b0, MAXP, 1'b0, 4, 1'b0, MAXP + 1, 1'b0, "R6 release at limit");
    run(1'b0, MAXP + 1, 1'b0, 4, 1'b0, MAXP + 1, 1'b1, "R6 past limit");
    run(1'b1, 0, 1'b1, 4, 1'b0, MAXP + 1, 1'b1, "R6 never released");
    // R8: status replaced at the next completion.
    run(1'b0, 0, 1'b0, 4, 1'b0, 0, 1'b0, "R8 status cleared");
    // R9: second start during a run is ignored.
    run(1'b0, 2, 1'b0, 4, 1'b1, 3, 1'b0, "R9 start while busy");
    // R10: start one cycle after SDA falls still sees the old level.
    run(1'b0, 2, 1'b0, 1, 1'b0, 0, 1'b0, "R10 sync latency");
    run(1'b0, 2, 1'b0, 3, 1'b0, 3, 1'b0, "R10 after sync");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: act %0d exp %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule